// File: doc/BRIEF.md
# Crystal Clock Loss Detector with Fallback Select

This block watches an external crystal clock while the system clock is being taken straight from that crystal, with the PLL bypassed. It times crystal activity against a separate reference clock. If the crystal stops toggling for longer than a programmed limit, nominally 1 µs, the block drives its clock-select output over to the PLL free-running base frequency. That frequency is somewhere between 750 kHz and 3 MHz, so the system keeps a working clock. The glitch-free multiplexer that acts on the select, and the PLL itself, sit outside this block.

Each crystal rising edge flips a toggle flop in the crystal domain. The toggle passes through a synchronizer into the reference domain, and any change seen there counts as activity. A timeout counter runs on the reference clock and is cleared by every detected edge. When the counter reaches its terminal count, a failure is latched. The failure holds the fallback selection until a system reset. A disable input stops monitoring altogether. While it is set and the PLL is bypassed, the crystal stays the clock source and the block asks for the PLL to be powered down. Both the timeout limit and the reference frequency are parameters, and the terminal count is derived from them.

Top module: `xtal_fallback_guard`

## Requirements
- R1: While `rst` is high, and on the first sampled cycle after it, `clk_sel` is 0 (crystal), `xtal_fail` is 0 and `pll_pwrdn` is 0.
- R2: With `pll_bypass`=1 and `mon_disable`=0, a crystal gap well under the timeout (about 35 reference cycles or less against a 50-cycle limit) leaves `clk_sel`=0 and `xtal_fail`=0.
- R3: With `pll_bypass`=1 and `mon_disable`=0, a crystal gap well over the timeout (80 or more reference cycles) sets `xtal_fail`=1 and `clk_sel`=1 (PLL base source). Both flags rise in the same cycle.
- R4: With `pll_bypass`=0, no crystal gap of any length sets `xtal_fail` or `clk_sel`.
- R5: With `mon_disable`=1 and `pll_bypass`=1, no crystal gap sets `xtal_fail`. `clk_sel` stays 0 and `pll_pwrdn` is 1.
- R6: Once `xtal_fail` is set, it and `clk_sel` stay 1 until `rst`, even after the crystal runs again.
- R7: Setting `mon_disable` while a failure is latched keeps `clk_sel`=1 and holds `pll_pwrdn` at 0.
- R8: A reset clears a latched failure. After the reset, `clk_sel` and `xtal_fail` are 0 again.
- R9: `pll_pwrdn` is 1 only when, one reference cycle earlier, `mon_disable`=1, `pll_bypass`=1 and no failure was latched. With `pll_bypass`=0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Independent reference clock that times the crystal |
| rst | input | 1 | Synchronous active-high system reset |
| xtal_clk | input | 1 | Monitored crystal clock |
| pll_bypass | input | 1 | 1 when the system clock is taken straight from the crystal |
| mon_disable | input | 1 | 1 turns monitoring off and requests PLL power-down |
| clk_sel | output | 1 | Clock source select: 0 crystal, 1 PLL base frequency |
| pll_pwrdn | output | 1 | Request to power down the PLL |
| xtal_fail | output | 1 | Latched crystal loss flag |

## Verification
The bench targets the edges of the timeout window. It stops the crystal once for well under the limit and once for well over it. A detector that switched on the short gap, or that never reached its terminal count, fails one of these two cases.

It also holds the crystal still in bypass-off and disabled modes. A design that ignored either gating would flag a failure there.

After a failure, the bench restarts the crystal and raises the disable input. A latch that did not stick would return to the crystal. A power-down not gated by the failure would turn off the PLL that the system is now running on. A final reset checks that the latch clears.

// File: rtl/xfg_pkg.sv
package xfg_pkg;
  typedef enum logic {
    SRC_XTAL     = 1'b0,
    SRC_PLL_BASE = 1'b1
  } clk_src_e;

  function automatic int unsigned ns_to_cycles(input int unsigned mhz,
                                               input int unsigned ns);
    return (mhz * ns + 999) / 1000;
  endfunction
endpackage

// File: rtl/xfg_edge_sync.sv
module xfg_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic xtal_clk,
  output logic activity
);
  logic              tog_q;
  logic [SYNC_STAGES:0] chain_q;

  // Crystal domain: flips on every crystal rising edge.
  always_ff @(posedge xtal_clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= ~tog_q;
  end

  // Reference domain: synchronizer plus one extra stage for change detect.
  always_ff @(posedge clk_ref) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= tog_q;
      for (int i = 1; i <= SYNC_STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign activity = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/xfg_timeout.sv
module xfg_timeout #(
  parameter int unsigned LIMIT = 50
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic armed,
  input  logic activity,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TERM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_ref) begin
    if (rst || !armed || activity) cnt_q <= '0;
    else if (cnt_q != TERM)        cnt_q <= cnt_q + 1'b1;
  end

  assign expired = armed && !activity && (cnt_q == TERM);

  // R3
  count_bound_chk: assert property (@(posedge clk_ref) disable iff (rst)
    cnt_q <= TERM);

  // R4
  disarm_clear_chk: assert property (@(posedge clk_ref) disable iff (rst)
    !armed |=> cnt_q == '0);
endmodule

// File: rtl/xtal_fallback_guard.sv
module xtal_fallback_guard
  import xfg_pkg::*;
#(
  parameter int unsigned REF_CLK_MHZ = 50,
  parameter int unsigned TIMEOUT_NS  = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic xtal_clk,
  input  logic pll_bypass,
  input  logic mon_disable,
  output logic clk_sel,
  output logic pll_pwrdn,
  output logic xtal_fail
);
  localparam int unsigned TIMEOUT_CYC = ns_to_cycles(REF_CLK_MHZ, TIMEOUT_NS);

  logic     activity;
  logic     expired;
  logic     armed;
  logic     fail_q;
  clk_src_e src_q;
  logic     pwrdn_q;

  xfg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_ref  (clk_ref),
    .rst      (rst),
    .xtal_clk (xtal_clk),
    .activity (activity)
  );

  assign armed = pll_bypass && !mon_disable && !fail_q;

  xfg_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk_ref  (clk_ref),
    .rst      (rst),
    .armed    (armed),
    .activity (activity),
    .expired  (expired)
  );

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      fail_q  <= 1'b0;
      src_q   <= SRC_XTAL;
      pwrdn_q <= 1'b0;
    end else begin
      if (expired) begin
        fail_q <= 1'b1;
        src_q  <= SRC_PLL_BASE;
      end
      pwrdn_q <= mon_disable && pll_bypass && !fail_q && !expired;
    end
  end

  assign xtal_fail = fail_q;
  assign clk_sel   = src_q;
  assign pll_pwrdn = pwrdn_q;

  // R6
  fail_sticky_chk: assert property (@(posedge clk_ref) disable iff (rst)
    xtal_fail |=> xtal_fail && clk_sel);

  // R3
  sel_matches_fail_chk: assert property (@(posedge clk_ref) disable iff (rst)
    clk_sel == xtal_fail);

  // R4
  fail_needs_monitor_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(xtal_fail) |-> $past(pll_bypass && !mon_disable));

  // R9
  pwrdn_gate_chk: assert property (@(posedge clk_ref) disable iff (rst)
    pll_pwrdn |-> $past(mon_disable && pll_bypass) && !clk_sel);

  // R7
  no_pwrdn_on_pll_chk: assert property (@(posedge clk_ref) disable iff (rst)
    clk_sel |-> !pll_pwrdn);
endmodule

// File: tb/xtal_fallback_guard_test.sv
module xtal_fallback_guard_test;
  logic clk_ref = 1'b0;
  logic rst = 1'b1;
  logic xtal_clk = 1'b0;
  logic xtal_run = 1'b1;
  logic pll_bypass = 1'b1;
  logic mon_disable = 1'b0;
  logic clk_sel, pll_pwrdn, xtal_fail;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk_ref = ~clk_ref;   // 50 MHz

  // Crystal at 5 MHz; stops cleanly when xtal_run is low.
  always begin
    if (xtal_run) #100 xtal_clk = ~xtal_clk;
    else          #20;
  end

  xtal_fallback_guard uut (
    .clk_ref     (clk_ref),
    .rst         (rst),
    .xtal_clk    (xtal_clk),
    .pll_bypass  (pll_bypass),
    .mon_disable (mon_disable),
    .clk_sel     (clk_sel),
    .pll_pwrdn   (pll_pwrdn),
    .xtal_fail   (xtal_fail)
  );

  typedef struct packed {
    logic        byp;
    logic        dis;
    logic [11:0] gap_100ns;
    logic        exp_fail;
    logic        exp_pwrdn;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{1'b1, 1'b0, 12'd4,  1'b0, 1'b0},   // R2 short gap
    '{1'b1, 1'b0, 12'd16, 1'b1, 1'b0},   // R3 long gap
    '{1'b0, 1'b0, 12'd16, 1'b0, 1'b0},   // R4 bypass off
    '{1'b1, 1'b1, 12'd16, 1'b0, 1'b1},   // R5 disabled
    '{1'b0, 1'b1, 12'd16, 1'b0, 1'b0}    // R9 disabled, bypass off
  };

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic ref_cycles(input int n);
    repeat (n) @(posedge clk_ref);
    @(negedge clk_ref);
  endtask

  task automatic do_reset();
    @(negedge clk_ref);
    rst = 1'b1;
    ref_cycles(4);
    rst = 1'b0;
  endtask

  task automatic crystal_gap(input int gap_100ns);
    xtal_run = 1'b0;
    #(gap_100ns * 100);
    xtal_run = 1'b1;
    ref_cycles(60);
  endtask

  initial begin
    #5ms;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    ref_cycles(4);
    check("R1", "clk_sel in reset", clk_sel, 1'b0);
    check("R1", "xtal_fail in reset", xtal_fail, 1'b0);
    check("R1", "pll_pwrdn in reset", pll_pwrdn, 1'b0);
    rst = 1'b0;
    ref_cycles(1);
    check("R1", "clk_sel after reset", clk_sel, 1'b0);

    for (int v = 0; v < 5; v++) begin
      pll_bypass  = VEC[v].byp;
      mon_disable = VEC[v].dis;
      do_reset();
      ref_cycles(50);
      crystal_gap(int'(VEC[v].gap_100ns));
      check($sformatf("R2-R5/R9 vec%0d", v), "xtal_fail", xtal_fail, VEC[v].exp_fail);
      check($sformatf("R3 vec%0d", v), "clk_sel", clk_sel, VEC[v].exp_fail);
      check($sformatf("R5/R9 vec%0d", v), "pll_pwrdn", pll_pwrdn, VEC[v].exp_pwrdn);
    end

    // R6: failure sticks with crystal running again
    pll_bypass = 1'b1; mon_disable = 1'b0;
    do_reset();
    ref_cycles(50);
    crystal_gap(16);
    ref_cycles(200);
    check("R6", "xtal_fail after resume", xtal_fail, 1'b1);
    check("R6", "clk_sel after resume", clk_sel, 1'b1);

    // R7: disable while latched
    mon_disable = 1'b1;
    ref_cycles(20);
    check("R7", "clk_sel with disable", clk_sel, 1'b1);
    check("R7", "pll_pwrdn with disable", pll_pwrdn, 1'b0);

    // R8: reset clears the latch
    mon_disable = 1'b0;
    do_reset();
    ref_cycles(2);
    check("R8", "xtal_fail after reset", xtal_fail, 1'b0);
    check("R8", "clk_sel after reset", clk_sel, 1'b0);

    // R9: disable alone with bypass on requests power-down in one cycle
    mon_disable = 1'b1;
    ref_cycles(1);
    check("R9", "pll_pwrdn one cycle after disable", pll_pwrdn, 1'b1);
    pll_bypass = 1'b0;
    ref_cycles(1);
    check("R9", "pll_pwrdn after bypass off", pll_pwrdn, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule